// File: doc/BRIEF.md
# Saturating Usage Log Accumulator

This block gathers wear and fault statistics for a board-level non-volatile log. Four 8-bit error tallies take increment pulses at any time, and a seconds counter advances on a one-second tick. A small byte image of the log lives in registers. A separate transfer engine fills it with the load port and reads it back with the read port.

When the host pulses `flush_req`, the block folds the pending tallies into the stored counts with saturation. It moves whole hours out of the seconds counter into a 16-bit hours field and keeps the leftover seconds. It then rewrites the checksum byte. It reports a per-byte change mask, the number of leading bytes that must be written back, and the new checksum. If nothing is pending, a flush finishes at once and changes nothing.

Image layout, by byte offset:

| Offset | Contents |
|---|---|
| 0 | Checksum |
| 1 to 4 | Error tallies 0 to 3 |
| 5 | Hours, low byte |
| 6 | Hours, high byte |
| 7 | Spare byte, never modified by a flush |

Top module: `ulog_accum`

## Requirements
- R1: A pulse on `inc_valid` adds `inc_amt` to the pending tally chosen by `inc_sel`. Tally k (0..3) merges into image byte 1+k.
- R2: A pending tally saturates at 255 and never wraps.
- R3: An active flush writes min(stored + pending, 255) into each tally byte and clears every pending tally.
- R4: A flush is a no-op when all pending tallies are zero and the seconds count is below 3600. In that case `done` pulses the cycle after the request, `chg_mask` and `wr_len` are 0, and the image, tallies and seconds stay unchanged.
- R5: Hours are moved only when the seconds count is strictly above 3600. The number moved is floor(seconds/3600), and the seconds counter keeps seconds mod 3600. At exactly 3600 a flush is active but moves no hours.
- R6: Hours are stored little-endian, low byte at offset 5 and high byte at offset 6. The new value is min(old + moved, 0xFFFF).
- R7: `chg_mask` bit k is 1 exactly when image byte k changed in the flush, and a byte is rewritten only when its value differs. `wr_len` is one more than the highest changed offset among 1..7, or 0 if none of them changed.
- R8: Every active flush writes the 8-bit sum of bytes 1..7 into byte 0, and `csum` shows that byte when `done` is high.
- R9: An increment presented in the cycle a flush is accepted, or while `busy` is high, counts toward the next flush and is not lost.
- R10: `busy` is high from the cycle after an active flush is accepted until the cycle `done` pulses. `done` is high for one cycle. Loads are ignored while `busy` is high.
- R11: When not busy, `ld_en` writes `ld_data` into byte `ld_addr`. `rd_data` always shows byte `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_valid | input | 1 | Increment strobe |
| inc_sel | input | 2 | Error tally index |
| inc_amt | input | 8 | Amount to add |
| sec_tick | input | 1 | One-second tick |
| flush_req | input | 1 | Flush request pulse |
| busy | output | 1 | Merge in progress |
| done | output | 1 | One-cycle pulse when the report outputs are valid |
| chg_mask | output | 8 | Changed-byte mask |
| wr_len | output | 4 | Write-back length in bytes |
| csum | output | 8 | Checksum byte after the flush |
| ld_en | input | 1 | Image load strobe |
| ld_addr | input | 3 | Image load offset |
| ld_data | input | 8 | Image load byte |
| rd_addr | input | 3 | Image read offset |
| rd_data | output | 8 | Image read byte |

## Verification
A pending tally that is held wrongly stays hidden until the next active flush. It then shows in the matching image byte, in its `chg_mask` bit and in `csum`, all on the `done` cycle. A wrong quotient from the hours divider shows at once in bytes 5 and 6. A wrong remainder shows only in a later flush, as a misplaced boundary between a no-op flush and an hours move. The directed tests therefore chain several flushes, so that leftover seconds and deferred increments are checked by the flush after the one that produced them.

// File: rtl/ulog_pkg.sv
package ulog_pkg;

    localparam int IMG_BYTES     = 8;
    localparam int ERR_CNT       = 4;
    localparam int OFS_CSUM      = 0;
    localparam int OFS_ERR0      = 1;
    localparam int OFS_HR_LO     = 5;
    localparam int OFS_HR_HI     = 6;
    localparam int SECS_PER_HOUR = 3600;
    localparam int LEN_W         = $clog2(IMG_BYTES + 1);
    localparam int ADDR_W        = $clog2(IMG_BYTES);

    typedef logic [7:0] byte_t;
    typedef logic [IMG_BYTES-1:0][7:0] image_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_MERGE,
        ST_CSUM
    } phase_t;

    typedef struct packed {
        logic [IMG_BYTES-1:0] mask;
        logic [LEN_W-1:0]     len;
        byte_t                csum;
    } report_t;

    function automatic byte_t sat_add8(byte_t a, byte_t b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[8] ? 8'hFF : s[7:0];
    endfunction

    function automatic byte_t image_sum(image_t img);
        byte_t acc;
        acc = 8'h00;
        for (int k = 1; k < IMG_BYTES; k++) acc = acc + img[k];
        return acc;
    endfunction

    function automatic logic [LEN_W-1:0] write_span(logic [IMG_BYTES-1:0] m);
        logic [LEN_W-1:0] len;
        len = '0;
        for (int k = 1; k < IMG_BYTES; k++)
            if (m[k]) len = LEN_W'(k + 1);
        return len;
    endfunction

endpackage

// File: rtl/ulog_err_bank.sv
module ulog_err_bank
    import ulog_pkg::*;
#(
    parameter int CNT = ERR_CNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     inc_valid,
    input  logic [$clog2(CNT)-1:0]   inc_sel,
    input  byte_t                    inc_amt,
    input  logic                     take,
    output logic [CNT-1:0][7:0]      snap,
    output logic                     any_pend
);

    byte_t pend_q [CNT];
    byte_t snap_q [CNT];

    for (genvar g = 0; g < CNT; g++) begin : g_cnt
        logic hit;
        assign hit = inc_valid && (int'(inc_sel) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 8'h00;
                snap_q[g] <= 8'h00;
            end else if (take) begin
                snap_q[g] <= pend_q[g];
                pend_q[g] <= hit ? inc_amt : 8'h00;
            end else if (hit) begin
                pend_q[g] <= sat_add8(pend_q[g], inc_amt);
            end
        end

        assign snap[g] = snap_q[g];

        // R2: without a merge, a pending tally only grows (saturates, never wraps)
        a_r2_pend_no_drop: assert property (@(posedge clk) disable iff (rst)
            !take |=> pend_q[g] >= $past(pend_q[g]));
        // R9: the captured value only moves when a flush is accepted
        a_r9_snap_hold: assert property (@(posedge clk) disable iff (rst)
            !take |=> $stable(snap_q[g]));
    end

    always_comb begin
        any_pend = 1'b0;
        for (int i = 0; i < CNT; i++) any_pend = any_pend | (pend_q[i] != 8'h00);
    end

endmodule

// File: rtl/ulog_hour_div.sv
module ulog_hour_div #(
    parameter int DIN_W   = 20,
    parameter int DIVISOR = 3600,
    parameter int REM_W   = $clog2(DIVISOR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIN_W-1:0]  din,
    output logic              done,
    output logic [DIN_W-1:0]  quot,
    output logic [REM_W-1:0]  rem
);

    localparam int TW    = REM_W + 1;
    localparam int CNT_W = $clog2(DIN_W + 1);
    localparam logic [TW-1:0] DIV_C = TW'(DIVISOR);

    logic [DIN_W-1:0] dvd_q, quot_q;
    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q;
    logic [TW-1:0]    trial, diff;
    logic             ge;

    assign trial = {rem_q, dvd_q[DIN_W-1]};
    assign ge    = trial >= DIV_C;
    assign diff  = trial - DIV_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            quot_q <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                dvd_q  <= din;
                quot_q <= '0;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(DIN_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= ge ? diff[REM_W-1:0] : trial[REM_W-1:0];
                quot_q <= {quot_q[DIN_W-2:0], ge};
                dvd_q  <= dvd_q << 1;
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = quot_q;
    assign rem  = rem_q;

    // R5: partial remainder always stays below one hour
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (rst)
        rem_q < REM_W'(DIVISOR));
    // R5: the division reports completion exactly when it stops stepping
    a_r5_div_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> done_q);

endmodule

// File: rtl/ulog_image.sv
module ulog_image
    import ulog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IMG_BYTES-1:0]  wr_en,
    input  image_t                wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output byte_t                 rd_data,
    output image_t                img
);

    byte_t mem_q [IMG_BYTES];

    for (genvar k = 0; k < IMG_BYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)           mem_q[k] <= 8'h00;
            else if (wr_en[k]) mem_q[k] <= wr_data[k];
        end
        assign img[k] = mem_q[k];

        // R7: a byte without a write strobe keeps its value
        a_r7_byte_hold: assert property (@(posedge clk) disable iff (rst)
            !wr_en[k] |=> $stable(mem_q[k]));
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ulog_accum.sv
module ulog_accum
    import ulog_pkg::*;
#(
    parameter int SEC_W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_valid,
    input  logic [1:0]   inc_sel,
    input  logic [7:0]   inc_amt,
    input  logic         sec_tick,
    input  logic         flush_req,
    output logic         busy,
    output logic         done,
    output logic [7:0]   chg_mask,
    output logic [3:0]   wr_len,
    output logic [7:0]   csum,
    input  logic         ld_en,
    input  logic [2:0]   ld_addr,
    input  logic [7:0]   ld_data,
    input  logic [2:0]   rd_addr,
    output logic [7:0]   rd_data
);

    localparam int REM_W  = $clog2(SECS_PER_HOUR);
    localparam int HSUM_W = ((SEC_W > 16) ? SEC_W : 16) + 1;
    localparam logic [SEC_W-1:0]  HOUR_S  = SEC_W'(SECS_PER_HOUR);
    localparam logic [HSUM_W-1:0] HRS_MAX = HSUM_W'(16'hFFFF);

    phase_t               state_q;
    report_t              rep_q;
    logic                 done_q;
    logic [SEC_W-1:0]     sec_q, sec_sub, sec_nx, snap_sec_q, quot;
    logic [REM_W-1:0]     rem;
    logic                 div_done, any_pend, active, take, take_hours;
    logic [ERR_CNT-1:0][7:0] snap_err;
    image_t               img_q, merged, wr_data;
    logic [IMG_BYTES-1:0] wr_en, merge_mask;
    logic [15:0]          hrs_old, hrs_new;
    logic [HSUM_W-1:0]    hrs_sum;
    byte_t                csum_new;

    ulog_err_bank #(.CNT(ERR_CNT)) u_err (
        .clk      (clk),
        .rst      (rst),
        .inc_valid(inc_valid),
        .inc_sel  (inc_sel),
        .inc_amt  (inc_amt),
        .take     (take),
        .snap     (snap_err),
        .any_pend (any_pend)
    );

    ulog_hour_div #(.DIN_W(SEC_W), .DIVISOR(SECS_PER_HOUR), .REM_W(REM_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .start(take),
        .din  (sec_q),
        .done (div_done),
        .quot (quot),
        .rem  (rem)
    );

    ulog_image u_img (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .img    (img_q)
    );

    assign active     = any_pend || (sec_q >= HOUR_S);
    assign take       = (state_q == ST_IDLE) && flush_req && active;
    assign take_hours = snap_sec_q > HOUR_S;

    // merged image: saturating tallies and saturating hours
    always_comb begin
        merged = img_q;
        for (int i = 0; i < ERR_CNT; i++)
            merged[OFS_ERR0+i] = sat_add8(img_q[OFS_ERR0+i], snap_err[i]);
        hrs_old = {img_q[OFS_HR_HI], img_q[OFS_HR_LO]};
        hrs_sum = HSUM_W'(hrs_old) + HSUM_W'(quot);
        if (!take_hours)          hrs_new = hrs_old;
        else if (hrs_sum > HRS_MAX) hrs_new = 16'hFFFF;
        else                      hrs_new = hrs_sum[15:0];
        merged[OFS_HR_LO] = hrs_new[7:0];
        merged[OFS_HR_HI] = hrs_new[15:8];
        for (int k = 0; k < IMG_BYTES; k++)
            merge_mask[k] = merged[k] != img_q[k];
    end

    assign csum_new = image_sum(img_q);

    // image write steering: loads when idle, differing bytes on merge, checksum last
    always_comb begin
        wr_en   = '0;
        wr_data = merged;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_en) begin
                    wr_en[ld_addr]   = 1'b1;
                    wr_data[ld_addr] = ld_data;
                end
            end
            ST_MERGE: wr_en = merge_mask;
            ST_CSUM: begin
                wr_en[OFS_CSUM]   = 1'b1;
                wr_data[OFS_CSUM] = csum_new;
            end
            default: wr_en = '0;
        endcase
    end

    // seconds: hours removed on merge, tick saturates at full scale
    always_comb begin
        sec_sub = sec_q;
        if (state_q == ST_MERGE && take_hours)
            sec_sub = sec_q - (snap_sec_q - SEC_W'(rem));
        sec_nx = (sec_tick && sec_sub != '1) ? sec_sub + 1'b1 : sec_sub;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            rep_q      <= '0;
            done_q     <= 1'b0;
            sec_q      <= '0;
            snap_sec_q <= '0;
        end else begin
            done_q <= 1'b0;
            sec_q  <= sec_nx;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        snap_sec_q <= sec_q;
                        state_q    <= ST_DIV;
                    end else if (flush_req) begin
                        rep_q.mask <= '0;
                        rep_q.len  <= '0;
                        rep_q.csum <= img_q[OFS_CSUM];
                        done_q     <= 1'b1;
                    end
                end
                ST_DIV: begin
                    if (div_done) state_q <= ST_MERGE;
                end
                ST_MERGE: begin
                    rep_q.mask <= merge_mask;
                    state_q    <= ST_CSUM;
                end
                ST_CSUM: begin
                    rep_q.mask[OFS_CSUM] <= csum_new != img_q[OFS_CSUM];
                    rep_q.len            <= write_span(rep_q.mask);
                    rep_q.csum           <= csum_new;
                    done_q               <= 1'b1;
                    state_q              <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = state_q != ST_IDLE;
    assign done     = done_q;
    assign chg_mask = rep_q.mask;
    assign wr_len   = rep_q.len;
    assign csum     = rep_q.csum;

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: leaving busy always coincides with done
    a_r10_busy_to_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R10: loads are blocked while the divider runs
    a_r10_no_load_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIV) |=> $stable(img_q));
    // R6: a merge never lowers the stored hours
    a_r6_hours_rise: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MERGE) |=> {img_q[OFS_HR_HI], img_q[OFS_HR_LO]}
                                  >= $past({img_q[OFS_HR_HI], img_q[OFS_HR_LO]}));
    // R5: without an hours transfer the seconds count does not drop
    a_r5_sec_kept: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MERGE && !take_hours) |=> sec_q >= $past(sec_q));
    // R7: no changed data byte means nothing to write back
    a_r7_len_zero: assert property (@(posedge clk) disable iff (rst)
        (done && chg_mask[IMG_BYTES-1:1] == '0) |-> wr_len == '0);
    // R8: reported checksum matches the stored checksum byte
    a_r8_csum_match: assert property (@(posedge clk) disable iff (rst)
        done |-> csum == img_q[OFS_CSUM]);

    for (genvar e = 0; e < ERR_CNT; e++) begin : g_chk
        // R3: a merge never lowers a stored tally
        a_r3_tally_rise: assert property (@(posedge clk) disable iff (rst)
            (state_q == ST_MERGE) |=> img_q[OFS_ERR0+e] >= $past(img_q[OFS_ERR0+e]));
    end

endmodule

// File: tb/ulog_accum_bench.sv
module ulog_accum_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc_valid = 1'b0;
    logic [1:0] inc_sel = '0;
    logic [7:0] inc_amt = '0;
    logic       sec_tick = 1'b0;
    logic       flush_req = 1'b0;
    logic       busy, done;
    logic [7:0] chg_mask, csum, rd_data;
    logic [3:0] wr_len;
    logic       ld_en = 1'b0;
    logic [2:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [2:0] rd_addr = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int m_img [8];
    int m_pend [4];
    int m_sec = 0;

    always #4 clk = ~clk;

    ulog_accum u_ulog_accum (
        .clk(clk), .rst(rst), .inc_valid(inc_valid), .inc_sel(inc_sel),
        .inc_amt(inc_amt), .sec_tick(sec_tick), .flush_req(flush_req),
        .busy(busy), .done(done), .chg_mask(chg_mask), .wr_len(wr_len),
        .csum(csum), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_byte(input int a, output int v);
        rd_addr = 3'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic check_image(input string tag);
        int v;
        for (int k = 0; k < 8; k++) begin
            read_byte(k, v);
            check($sformatf("%s byte%0d", tag, k), v, m_img[k]);
        end
    endtask

    task automatic load_byte(input int a, input int d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 3'(a); ld_data = 8'(d);
        @(negedge clk);
        ld_en = 1'b0;
        m_img[a] = d;
    endtask

    task automatic bump(input int sel, input int amt);
        @(negedge clk);
        inc_valid = 1'b1; inc_sel = 2'(sel); inc_amt = 8'(amt);
        @(negedge clk);
        inc_valid = 1'b0;
        m_pend[sel] = (m_pend[sel] + amt > 255) ? 255 : m_pend[sel] + amt;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
        m_sec += n;
    endtask

    // flush with expected outcome derived from the requirement model
    task automatic run_flush(input string tag, input bit poke, input bit inc_same, input bit inc_busy);
        int exp_img [8];
        int exp_mask, exp_len, sum, hrs, h, any;
        bit act, got;
        any = 0;
        for (int i = 0; i < 4; i++) if (m_pend[i] != 0) any = 1;
        act = (any != 0) || (m_sec >= 3600);
        for (int k = 0; k < 8; k++) exp_img[k] = m_img[k];
        exp_mask = 0; exp_len = 0;
        if (act) begin
            for (int i = 0; i < 4; i++)
                exp_img[1+i] = (m_img[1+i] + m_pend[i] > 255) ? 255 : m_img[1+i] + m_pend[i];
            if (m_sec > 3600) begin
                h = m_sec / 3600;
                hrs = m_img[5] + 256 * m_img[6] + h;
                if (hrs > 65535) hrs = 65535;
                exp_img[5] = hrs % 256;
                exp_img[6] = hrs / 256;
                m_sec = m_sec - h * 3600;
            end
            for (int k = 1; k < 8; k++)
                if (exp_img[k] != m_img[k]) begin
                    exp_mask |= (1 << k);
                    exp_len = k + 1;
                end
            sum = 0;
            for (int k = 1; k < 8; k++) sum += exp_img[k];
            sum = sum % 256;
            if (sum != m_img[0]) exp_mask |= 1;
            exp_img[0] = sum;
            for (int i = 0; i < 4; i++) m_pend[i] = 0;
        end
        @(negedge clk);
        flush_req = 1'b1;
        if (inc_same) begin inc_valid = 1'b1; inc_sel = 2'd3; inc_amt = 8'd7; end
        @(negedge clk);
        flush_req = 1'b0;
        inc_valid = 1'b0;
        if (act) check({tag, " R10 busy"}, int'(busy), 1);
        got = 1'b0;
        for (int w = 0; w < 200; w++) begin
            if (done) begin got = 1'b1; break; end
            if (w == 0) begin
                if (poke) begin ld_en = 1'b1; ld_addr = 3'd7; ld_data = 8'hAA; end
                if (inc_busy) begin inc_valid = 1'b1; inc_sel = 2'd0; inc_amt = 8'd9; end
            end else begin
                ld_en = 1'b0;
                inc_valid = 1'b0;
            end
            @(negedge clk);
        end
        ld_en = 1'b0;
        inc_valid = 1'b0;
        check({tag, " R10 done seen"}, int'(got), 1);
        check({tag, " R7 mask"}, int'(chg_mask), exp_mask);
        check({tag, " R7 len"}, int'(wr_len), exp_len);
        check({tag, " R8 csum"}, int'(csum), exp_img[0]);
        @(negedge clk);
        check({tag, " R10 done single"}, int'(done), 0);
        check({tag, " R10 idle"}, int'(busy), 0);
        for (int k = 0; k < 8; k++) m_img[k] = exp_img[k];
        if (inc_same) m_pend[3] = (m_pend[3] + 7 > 255) ? 255 : m_pend[3] + 7;
        if (inc_busy) m_pend[0] = (m_pend[0] + 9 > 255) ? 255 : m_pend[0] + 9;
        check_image(tag);
    endtask

    task automatic t_reset;
        check("R10 reset busy", int'(busy), 0);
        check("R10 reset done", int'(done), 0);
        check("R7 reset mask", int'(chg_mask), 0);
        check("R7 reset len", int'(wr_len), 0);
        check_image("R11 reset");
    endtask

    task automatic t_noop;
        ticks(10);
        run_flush("R4 idle flush", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_load;
        load_byte(0, 8'h11); load_byte(1, 10);  load_byte(2, 250);
        load_byte(3, 0);     load_byte(4, 3);   load_byte(5, 8'hFE);
        load_byte(6, 0);     load_byte(7, 8'h5A);
        check_image("R11 load");
    endtask

    task automatic t_err_merge;
        bump(0, 5); bump(0, 6); bump(1, 20);
        run_flush("R1 R3 merge", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_pend_sat;
        bump(2, 200); bump(2, 200);
        run_flush("R2 pend sat", 1'b0, 1'b0, 1'b0);
        run_flush("R3 cleared R4", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle;
        bump(0, 1);
        run_flush("R9 R10 accept", 1'b1, 1'b1, 1'b1);
        run_flush("R9 deferred", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hours;
        ticks(7290);
        run_flush("R5 R6 two hours", 1'b0, 1'b0, 1'b0);
        ticks(3500);
        run_flush("R5 exact hour", 1'b0, 1'b0, 1'b0);
        ticks(1);
        run_flush("R5 R7 low byte", 1'b0, 1'b0, 1'b0);
        ticks(3598);
        run_flush("R5 R4 remainder", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hours_sat;
        load_byte(5, 8'hFE);
        load_byte(6, 8'hFF);
        ticks(7201);
        run_flush("R6 hours sat", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_img[i] = 0;
        for (int i = 0; i < 4; i++) m_pend[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_noop();
        t_load();
        t_err_merge();
        t_pend_sat();
        t_same_cycle();
        t_hours();
        t_hours_sat();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule